// File: doc/BRIEF.md
# Ethernet Receive Traffic Monitor

This block watches a byte-wide stream of Ethernet frames, delimited by start and end markers, and sorts each completed frame by its frame check sequence. A frame whose CRC-32 checks out adds one to a pass tally. Any other frame adds one to a fail tally. Software sets a target number of frames. The monitor then measures the bytes and the clock cycles needed to reach that number. When the target is met it stops all counting and raises a completion flag.

The block is meant for link bring-up and throughput tests. Software writes the target, pulses the clear bit and starts a traffic source. It then waits for the completion flag and reads the tallies. It can work out throughput as bytes divided by cycles. The stream input never stalls, so the ready output is held high. The two 64-bit counters are read as a low word followed by a high word. Reading the low word captures the high word, so the pair is always consistent.

Top module: `eth_rx_monitor`

## Requirements
- R1: After reset, the target register (offset 0x00) reads 0xFFFFFFFF. The pass tally, fail tally, byte counter, cycle counter and control/status register all read 0. The target register can be written and read back.
- R2: A frame is good when the reflected CRC-32 (initial value all ones, polynomial 0xEDB88320), run over every byte of the frame including its last four, leaves 0xDEBB20E3 in the LSB-first register. That value is 0xC704DD7B bit-reversed. The trailer holds the inverted CRC of the preceding bytes, least significant byte first. Each good frame adds 1 to the pass tally at offset 0x04.
- R3: Each frame that fails the R2 check adds 1 to the fail tally at offset 0x08. A frame shorter than four bytes, including a one-byte frame with both markers set, is still classified by the same rule.
- R4: in_ready is always 1. Every byte with in_valid high adds 1 to the 64-bit byte counter, trailer bytes included. The low word is at offset 0x0C and the high word at offset 0x10.
- R5: The 64-bit cycle counter (low word 0x14, high word 0x18) stays at 0 until the first accepted start-of-frame byte after a clear. It then counts every cycle, up to and including the cycle that accepts the end byte of the frame that completes the target.
- R6: When the pass and fail tallies together first equal the target at an end-of-frame byte, bit 2 of the control/status register (offset 0x1C) becomes 1. From then on, further frames change none of the tallies or counters.
- R7: Writing 1 to bit 0 of the control/status register clears the tallies, both counters and the completion flag. It leaves the target unchanged. Bit 0 reads back as 0 once the write has taken effect.
- R8: A read of a low word (0x0C or 0x14) captures the matching high word. The next read of 0x10 or 0x18 returns that captured value.
- R9: Read data appears on reg_rdata in the cycle after reg_rd is high. Offsets that are not mapped, and reserved bits, read 0. Writes to read-only offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stream byte present |
| in_ready | output | 1 | Always 1; the stream is never stalled |
| in_data | input | 8 | Stream byte |
| in_sop | input | 1 | First byte of a frame |
| in_eop | input | 1 | Last byte of a frame |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after reg_rd |

## Verification
The completion assertion assumes that software does not rewrite the target in the same cycle that the final frame ends. The stimulus changes the target only while the stream is idle, before a clear. The step-size properties assume that at most one byte and one frame end arrive per cycle. The stimulus drives one byte per cycle with marked frame boundaries, and it issues a clear only between frames. Frames are otherwise random in length, content, corruption and inter-frame gap, including back-to-back frames.

// File: rtl/mon_pkg.sv
package mon_pkg;

    localparam int DATA_W     = 8;
    localparam int REG_AW     = 6;
    localparam int REG_DW     = 32;
    localparam int FRM_CNT_W  = 32;
    localparam int WIDE_CNT_W = 64;
    localparam int CRC_W      = 32;
    localparam int HALF_W     = WIDE_CNT_W / 2;

    localparam logic [CRC_W-1:0] CRC_SEED     = 32'hFFFF_FFFF;
    localparam logic [CRC_W-1:0] CRC_POLY_REV = 32'hEDB8_8320;
    localparam logic [CRC_W-1:0] CRC_MAGIC    = 32'hC704_DD7B;
    localparam logic [REG_DW-1:0] TARGET_RST  = 32'hFFFF_FFFF;

    typedef enum logic [2:0] {
        RG_TARGET  = 3'd0,
        RG_PASS    = 3'd1,
        RG_FAIL    = 3'd2,
        RG_BYTE_LO = 3'd3,
        RG_BYTE_HI = 3'd4,
        RG_CYC_LO  = 3'd5,
        RG_CYC_HI  = 3'd6,
        RG_CTRL    = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic              valid;
        logic              sop;
        logic              eop;
        logic [DATA_W-1:0] data;
    } beat_t;

    typedef struct packed {
        logic fin;
        logic good;
    } verdict_t;

    typedef struct packed {
        logic [FRM_CNT_W-1:0]  pass;
        logic [FRM_CNT_W-1:0]  fail;
        logic [WIDE_CNT_W-1:0] bytes;
        logic [WIDE_CNT_W-1:0] cycles;
        logic                  done;
    } stats_t;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c_in,
                                                  input logic [DATA_W-1:0] d);
        logic [CRC_W-1:0] c;
        c = c_in;
        for (int i = 0; i < DATA_W; i++) begin
            if (c[0] ^ d[i]) c = (c >> 1) ^ CRC_POLY_REV;
            else             c = c >> 1;
        end
        return c;
    endfunction

    function automatic logic [CRC_W-1:0] bit_rev(input logic [CRC_W-1:0] v);
        logic [CRC_W-1:0] r;
        for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
        return r;
    endfunction

endpackage

// File: rtl/mon_crc_check.sv
module mon_crc_check
    import mon_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  beat_t    beat_i,
    output verdict_t verdict_o
);
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] seed;
    logic [CRC_W-1:0] crc_nx;

    always_comb begin
        seed           = beat_i.sop ? CRC_SEED : crc_q;
        crc_nx         = crc_step(seed, beat_i.data);
        verdict_o.fin  = beat_i.valid && beat_i.eop;
        verdict_o.good = verdict_o.fin && (bit_rev(crc_nx) == CRC_MAGIC);
    end

    always_ff @(posedge clk) begin
        if (rst || clr)        crc_q <= CRC_SEED;
        else if (beat_i.valid) crc_q <= crc_nx;
    end
endmodule

// File: rtl/mon_counters.sv
module mon_counters
    import mon_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  beat_t                beat_i,
    input  verdict_t             verdict_i,
    input  logic [REG_DW-1:0]    target_i,
    output stats_t               stats_o
);
    stats_t               st_q;
    logic                 running_q;
    logic                 start_now;
    logic [FRM_CNT_W-1:0] total_nx;

    always_comb begin
        start_now = beat_i.valid && beat_i.sop;
        total_nx  = st_q.pass + st_q.fail + FRM_CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st_q      <= '0;
            running_q <= 1'b0;
        end else if (!st_q.done) begin
            if (beat_i.valid)
                st_q.bytes <= st_q.bytes + WIDE_CNT_W'(1);
            if (running_q || start_now) begin
                st_q.cycles <= st_q.cycles + WIDE_CNT_W'(1);
                running_q   <= 1'b1;
            end
            if (verdict_i.fin) begin
                if (verdict_i.good) st_q.pass <= st_q.pass + FRM_CNT_W'(1);
                else                st_q.fail <= st_q.fail + FRM_CNT_W'(1);
                if (total_nx == target_i) st_q.done <= 1'b1;
            end
        end
    end

    assign stats_o = st_q;
endmodule

// File: rtl/mon_regs.sv
module mon_regs
    import mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  stats_t            stats_i,
    output logic [REG_DW-1:0] target_o,
    output logic              clr_o
);
    logic [REG_DW-1:0] target_q;
    logic              clr_q;
    logic [HALF_W-1:0] byte_hi_q;
    logic [HALF_W-1:0] cyc_hi_q;
    logic [REG_DW-1:0] rdata_q;
    logic [REG_DW-1:0] rd_mux;
    logic              mapped;
    reg_sel_e          sel;

    always_comb begin
        sel    = reg_sel_e'(reg_addr[4:2]);
        mapped = (reg_addr[REG_AW-1] == 1'b0) && (reg_addr[1:0] == 2'b00);
        case (sel)
            RG_TARGET:  rd_mux = target_q;
            RG_PASS:    rd_mux = stats_i.pass;
            RG_FAIL:    rd_mux = stats_i.fail;
            RG_BYTE_LO: rd_mux = stats_i.bytes[HALF_W-1:0];
            RG_BYTE_HI: rd_mux = byte_hi_q;
            RG_CYC_LO:  rd_mux = stats_i.cycles[HALF_W-1:0];
            RG_CYC_HI:  rd_mux = cyc_hi_q;
            RG_CTRL:    rd_mux = {29'd0, stats_i.done, 1'b0, clr_q};
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            target_q  <= TARGET_RST;
            clr_q     <= 1'b0;
            byte_hi_q <= '0;
            cyc_hi_q  <= '0;
            rdata_q   <= '0;
        end else begin
            clr_q <= 1'b0;
            if (reg_wr && mapped) begin
                if (sel == RG_TARGET) target_q <= reg_wdata;
                if (sel == RG_CTRL)   clr_q    <= reg_wdata[0];
            end
            if (reg_rd) begin
                rdata_q <= mapped ? rd_mux : '0;
                if (mapped && sel == RG_BYTE_LO) byte_hi_q <= stats_i.bytes[WIDE_CNT_W-1:HALF_W];
                if (mapped && sel == RG_CYC_LO)  cyc_hi_q  <= stats_i.cycles[WIDE_CNT_W-1:HALF_W];
            end
        end
    end

    assign reg_rdata = rdata_q;
    assign target_o  = target_q;
    assign clr_o     = clr_q;
endmodule

// File: rtl/eth_rx_monitor.sv
module eth_rx_monitor
    import mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata
);
    beat_t             beat_w;
    verdict_t          verdict_w;
    stats_t            stats_w;
    logic [REG_DW-1:0] target_w;
    logic              clr_w;

    assign in_ready = 1'b1;
    assign beat_w   = '{valid: in_valid, sop: in_sop, eop: in_eop, data: in_data};

    mon_crc_check u_crc (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr_w),
        .beat_i    (beat_w),
        .verdict_o (verdict_w)
    );

    mon_counters u_cnt (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr_w),
        .beat_i    (beat_w),
        .verdict_i (verdict_w),
        .target_i  (target_w),
        .stats_o   (stats_w)
    );

    mon_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .stats_i   (stats_w),
        .target_o  (target_w),
        .clr_o     (clr_w)
    );
endmodule

// File: rtl/mon_checker.sv
module mon_checker
    import mon_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              clr,
    input logic              in_valid,
    input logic              in_sop,
    input logic [REG_DW-1:0] target,
    input stats_t            st
);
    logic [FRM_CNT_W-1:0] total;
    assign total = st.pass + st.fail;

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
        clr |=> (st.pass == 0 && st.fail == 0 && st.bytes == 0 && st.cycles == 0 && !st.done)); // R7
    AST_DONE_STICKS: assert property (@(posedge clk) disable iff (rst)
        (st.done && !clr) |=> st.done); // R6
    AST_FROZEN_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        (st.done && !clr) |=> ($stable(st.pass) && $stable(st.fail) && $stable(st.bytes) && $stable(st.cycles))); // R6
    AST_DONE_AT_TARGET: assert property (@(posedge clk) disable iff (rst)
        $rose(st.done) |-> (total == target)); // R6
    AST_ONE_FRAME_STEP: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (total == $past(total) || total == $past(total) + FRM_CNT_W'(1))); // R2
    AST_BYTE_STEP: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (st.bytes == $past(st.bytes) || st.bytes == $past(st.bytes) + WIDE_CNT_W'(1))); // R4
    AST_CYCLES_WAIT_SOP: assert property (@(posedge clk) disable iff (rst)
        (!clr && st.cycles == 0 && !(in_valid && in_sop)) |=> st.cycles == 0); // R5
endmodule

bind eth_rx_monitor mon_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr_w),
    .in_valid (in_valid),
    .in_sop   (in_sop),
    .target   (target_w),
    .st       (stats_w)
);

// File: tb/sim_eth_rx_monitor.sv
module sim_eth_rx_monitor;
    logic        clk = 0;
    logic        rst = 1;
    logic        in_valid = 0;
    logic        in_ready;
    logic [7:0]  in_data = 0;
    logic        in_sop = 0;
    logic        in_eop = 0;
    logic        reg_wr = 0;
    logic        reg_rd = 0;
    logic [5:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    longint tb_cyc = 0;

    logic [7:0] fb [0:127];
    int flen;

    int     m_pass, m_fail, m_total;
    longint m_bytes, m_start, m_end;
    logic [31:0] m_target;
    bit     m_done, m_started;

    eth_rx_monitor u0 (.*);

    always #2 clk = ~clk;
    always @(posedge clk) tb_cyc <= tb_cyc + 1;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input int n);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int k = 0; k < n; k++)
            for (int b = 0; b < 8; b++) begin
                logic fb_bit = c[0] ^ fb[k][b];
                c = c >> 1;
                if (fb_bit) c = c ^ 32'hEDB88320;
            end
        return c;
    endfunction

    task automatic build_frame(input int plen, input bit corrupt);
        logic [31:0] fcs;
        for (int k = 0; k < plen; k++) fb[k] = 8'($urandom);
        fcs = ~ref_crc(plen);
        for (int k = 0; k < 4; k++) fb[plen+k] = fcs[8*k +: 8];
        flen = plen + 4;
        if (corrupt) begin
            int p = int'($urandom % flen);
            fb[p] = fb[p] ^ (8'd1 << ($urandom % 8));
        end
    endtask

    task automatic send_frame(input int gap);
        bit good = (ref_crc(flen) == 32'hDEBB20E3);
        for (int k = 0; k < flen; k++) begin
            @(negedge clk);
            in_valid = 1; in_data = fb[k]; in_sop = (k == 0); in_eop = (k == flen - 1);
            if (!m_done) begin
                m_bytes++;
                if (k == 0 && !m_started) begin m_started = 1; m_start = tb_cyc + 1; end
                if (k == flen - 1) begin
                    if (good) m_pass++; else m_fail++;
                    m_total++;
                    if (32'(m_total) == m_target) begin m_done = 1; m_end = tb_cyc + 1; end
                end
            end
        end
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            in_valid = 0; in_sop = 0; in_eop = 0;
        end
    endtask

    task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        in_valid = 0; in_sop = 0; in_eop = 0;
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic reg_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        in_valid = 0; in_sop = 0; in_eop = 0;
        reg_rd = 1; reg_addr = a;
        @(negedge clk);
        reg_rd = 0;
        d = reg_rdata;
    endtask

    task automatic clear_mon();
        reg_write(6'h1C, 32'h1);
        @(negedge clk);
        m_pass = 0; m_fail = 0; m_total = 0; m_bytes = 0;
        m_done = 0; m_started = 0; m_start = 0; m_end = 0;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v, lo;
        reg_read(6'h00, v);  chk({tag, " R1 target"}, 64'(v), 64'(m_target));
        reg_read(6'h04, v);  chk({tag, " R2 pass"}, 64'(v), 64'(m_pass));
        reg_read(6'h08, v);  chk({tag, " R3 fail"}, 64'(v), 64'(m_fail));
        reg_read(6'h0C, lo); reg_read(6'h10, v);
        chk({tag, " R4 bytes"}, {v, lo}, 64'(m_bytes));
        reg_read(6'h1C, v);  chk({tag, " R6 done flag"}, 64'(v), m_done ? 64'h4 : 64'h0);
        if (m_done) begin
            reg_read(6'h14, lo); reg_read(6'h18, v);
            chk({tag, " R5 cycles"}, {v, lo}, 64'(m_end - m_start + 1));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd1357));
        m_target = 32'hFFFFFFFF;
        m_pass = 0; m_fail = 0; m_total = 0; m_bytes = 0;
        m_done = 0; m_started = 0; m_start = 0; m_end = 0;
        repeat (5) @(negedge clk);
        rst = 0;

        // R1 reset state
        reg_read(6'h00, v); chk("R1 reset target", 64'(v), 64'hFFFFFFFF);
        reg_read(6'h04, v); chk("R1 reset pass", 64'(v), 0);
        reg_read(6'h08, v); chk("R1 reset fail", 64'(v), 0);
        reg_read(6'h0C, v); chk("R1 reset bytes lo", 64'(v), 0);
        reg_read(6'h14, v); chk("R1 reset cycles lo", 64'(v), 0);
        reg_read(6'h1C, v); chk("R1 reset ctrl", 64'(v), 0);

        // R9 read-only and unmapped offsets
        reg_write(6'h04, 32'h55); reg_read(6'h04, v); chk("R9 write to read-only ignored", 64'(v), 0);
        reg_read(6'h24, v); chk("R9 unmapped reads zero", 64'(v), 0);
        reg_write(6'h00, 32'd5); m_target = 5;
        reg_read(6'h00, v); chk("R1 target write/readback", 64'(v), 5);
        chk("R4 ready held high", 64'(in_ready), 1);

        // Directed frames: one-byte frame, long good, corrupted, back-to-back, gapped
        clear_mon();
        reg_read(6'h14, v); chk("R5 cycles idle before sop", 64'(v), 0);
        flen = 1; fb[0] = 8'hA5; send_frame(1);
        build_frame(60, 0); send_frame(0);
        build_frame(20, 1); send_frame(0);
        build_frame(0, 0);  send_frame(0);
        build_frame(12, 0); send_frame(2);
        check_all("directed");

        // R6 frames after done are ignored
        build_frame(30, 0); send_frame(0);
        build_frame(8, 1);  send_frame(1);
        check_all("after-done R6");

        // R7 clear keeps target, bit0 self-clears
        clear_mon();
        check_all("clear R7");
        reg_read(6'h1C, v); chk("R7 ctrl bit0 self-clears", 64'(v), 0);
        reg_read(6'h00, v); chk("R7 target kept", 64'(v), 5);

        // R8 coherent wide read after traffic
        build_frame(10, 0); send_frame(1);
        reg_read(6'h0C, v); chk("R8 bytes lo", 64'(v), 14);
        reg_read(6'h10, v); chk("R8 bytes hi captured", 64'(v), 0);

        // Random rounds
        for (int r = 0; r < 10; r++) begin
            m_target = 32'(2 + $urandom % 6);
            reg_write(6'h00, m_target);
            clear_mon();
            for (int f = 0; f < int'(m_target); f++) begin
                build_frame(int'($urandom % 61), ($urandom % 3) == 0);
                send_frame(int'($urandom % 4));
            end
            check_all($sformatf("random%0d", r));
        end

        // Default-like large target: never completes
        m_target = 32'hFFFFFFFF;
        reg_write(6'h00, m_target);
        clear_mon();
        for (int f = 0; f < 3; f++) begin
            build_frame(int'($urandom % 40), f == 1);
            send_frame(1);
        end
        check_all("no-done R6");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule